// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a chip's internal registers from an external serial EEPROM so that the chip can run with no management host attached. Any of three reset causes starts a load: power-on, the external reset pin, or a digital reset that software requests through a control bit. Each arrives as a one-cycle pulse. A host can also request a load by issuing a reload command, but only while the loader is idle. Two strap inputs describe the memory. One selects a two-wire (I2C) or a three-wire (Microwire) device, and a two-bit code selects its size. Both are captured when a load starts and are passed to the bit-level engine.

The loader fetches one byte at a time through a request/response port to an external bit-level engine. Byte 0 must hold the signature 0xA5. After it comes a packed stream of five-byte records. Each record is a register address byte followed by a 32-bit value, least significant byte first. Every complete record becomes one write on the register-bus master port. The stream ends at an address byte of 0xFF or at the last address the size strap allows. A new reset cause during a load restarts the load from byte 0. An engine timeout ends the load and sets a status flag.

All three data interfaces use valid/ready. A source raises valid and holds valid, address and data unchanged until the cycle in which ready is also high; that cycle is the transfer. The engine may hold off requests with `rd_req_ready` and the register bus may hold off writes with `wr_ready` for any number of cycles. The loader raises `rd_rsp_ready` only while it waits for a byte and keeps at most one read outstanding.

Top module: `cfgld_top`

## Requirements
- R1: A one-cycle pulse on `por_evt`, `pin_rst_evt` or `dig_rst_evt` starts a load, and the first byte requested is address 0.
- R2: A `host_reload` pulse while `cmd_busy` is low starts a load. A pulse while `cmd_busy` is high is ignored: the running load continues with the same read address sequence and no extra read of address 0.
- R3: When a load starts, `eep_mw` takes `strap_mw` (1 = three-wire, 0 = two-wire) and `eep_abits` takes 7 + `strap_size`. Strap changes during a load do not change either output.
- R4: If byte 0 is not 0xA5, the load ends after that single read with `stat_loaded` = 0, `stat_timeout` = 0 and no register write.
- R5: After the signature, bytes are read at consecutive addresses. The record at offset a yields one write with `wr_addr` = byte a and `wr_data` = {byte a+4, a+3, a+2, a+1}, and writes leave in record order.
- R6: An address byte of 0xFF ends the load with `stat_loaded` = 1. The load also ends with `stat_loaded` = 1 when the next address would pass 2^`eep_abits` − 1. No address beyond that limit is requested, and a record cut off by the limit is not written.
- R7: A response with `rd_rsp_timeout` = 1 ends the load with `stat_timeout` = 1 and `stat_loaded` = 0, and no further read or write follows.
- R8: A reset-cause pulse during a load restarts it. The loader drops any response still owed to the old load, requests address 0 next, and clears both status flags at the restart.
- R9: Once `rd_req_valid` or `wr_valid` is raised, it stays high with a stable address and data until the matching ready. At most one of `rd_req_valid`, `rd_rsp_ready` and `wr_valid` is high in any cycle.
- R10: `cmd_busy` is low after reset and rises in the cycle after an accepted trigger. It stays high until the load ends, and every read request and register write occurs while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_evt | input | 1 | Power-on reset cause pulse |
| pin_rst_evt | input | 1 | External reset pin cause pulse |
| dig_rst_evt | input | 1 | Software digital reset cause pulse |
| strap_mw | input | 1 | EEPROM type strap (1 = three-wire) |
| strap_size | input | 2 | EEPROM size strap |
| host_reload | input | 1 | Host reload command pulse |
| cmd_busy | output | 1 | Load in progress or pending |
| stat_loaded | output | 1 | Last load completed with a valid signature |
| stat_timeout | output | 1 | Last load ended on an engine timeout |
| eep_mw | output | 1 | Captured device type for the engine |
| eep_abits | output | 4 | Captured address width for the engine |
| rd_req_valid | output | 1 | Byte read request valid |
| rd_req_ready | input | 1 | Engine accepts request |
| rd_req_addr | output | 10 | Byte address to read |
| rd_rsp_valid | input | 1 | Engine response valid |
| rd_rsp_ready | output | 1 | Loader accepts response |
| rd_rsp_data | input | 8 | Byte read |
| rd_rsp_timeout | input | 1 | Engine gave up on this byte |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register bus accepts write |
| wr_addr | output | 8 | Register address |
| wr_data | output | 32 | Register value |

## Verification
A wrong byte counter or phase shows at the read port within one request: the next `rd_req_addr` leaves the expected sequence, or a write carries bytes from the wrong lanes. A bad restart or a dropped discard shows as a request that is not address 0 after the pulse. A wrong end condition shows as a read beyond the size limit or a missing final status once `cmd_busy` falls. A lost trigger shows one cycle later as `cmd_busy` still low.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  // sequencer states: one open handshake per state
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WRITE = 2'd3
  } ld_state_t;

  typedef enum logic {
    PH_SIG = 1'b0,
    PH_REC = 1'b1
  } ld_phase_t;

  localparam logic [7:0] DEF_SIG_BYTE = 8'hA5;
  localparam logic [7:0] DEF_END_BYTE = 8'hFF;
endpackage

// File: rtl/cfgld_trig.sv
// Collects reset causes and the host command into one pending start.
module cfgld_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic por_evt,
  input  logic pin_rst_evt,
  input  logic dig_rst_evt,
  input  logic host_reload,
  input  logic core_busy,
  input  logic consume,
  output logic pend,
  output logic busy
);
  logic cause_any;
  logic host_ok;

  assign cause_any = por_evt | pin_rst_evt | dig_rst_evt;
  assign busy      = core_busy | pend;
  // host command only counts when nothing runs or waits
  assign host_ok   = host_reload & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pend <= 1'b0;
    else if (cause_any || host_ok) pend <= 1'b1;
    else if (consume)              pend <= 1'b0;
  end
endmodule

// File: rtl/cfgld_geom.sv
// Captures the straps at load start and bounds the address space.
module cfgld_geom #(
  parameter int ADDR_W    = 10,
  parameter int MIN_ABITS = 7,
  localparam int ABITS_W  = $clog2(ADDR_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               strap_mw,
  input  logic [1:0]         strap_size,
  input  logic [ADDR_W:0]    cur_addr,
  output logic               eep_mw,
  output logic [ABITS_W-1:0] eep_abits,
  output logic               past_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eep_mw    <= 1'b0;
      eep_abits <= ABITS_W'(MIN_ABITS);
    end else if (capture) begin
      eep_mw    <= strap_mw;
      eep_abits <= ABITS_W'(MIN_ABITS) + ABITS_W'(strap_size);
    end
  end

  // any bit at or above the captured width means the device is exhausted
  assign past_end = |(cur_addr >> eep_abits);
endmodule

// File: rtl/cfgld_rec.sv
// Assembles one record: an address byte followed by little-endian data lanes.
module cfgld_rec #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        din,
  output logic [7:0]        rec_addr,
  output logic [DATA_W-1:0] rec_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rec_addr <= '0;
    else if (we && idx == IDX_W'(0))  rec_addr <= din;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rec_data[g*8 +: 8] <= '0;
      else if (we && idx == IDX_W'(g + 1)) rec_data[g*8 +: 8] <= din;
    end
  end
endmodule

// File: rtl/cfgld_seq.sv
// Load sequencer: signature check, record walk, write issue, restart.
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter int         DATA_W   = 32,
  parameter logic [7:0] SIG_BYTE = DEF_SIG_BYTE,
  parameter logic [7:0] END_BYTE = DEF_END_BYTE,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend,
  input  logic             past_end,
  output logic             start_now,
  output logic             core_busy,
  output logic [ADDR_W:0]  cur_addr,
  output logic [IDX_W-1:0] idx,
  output logic             rec_we,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  input  logic             rd_rsp_valid,
  output logic             rd_rsp_ready,
  input  logic [7:0]       rd_rsp_data,
  input  logic             rd_rsp_timeout,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic             stat_loaded,
  output logic             stat_timeout
);
  ld_state_t st;
  ld_phase_t phase;
  logic      rsp_fire;
  logic      take;
  logic      last_lane;

  assign rsp_fire  = (st == ST_WAIT) && rd_rsp_valid;
  // a pending start is taken only where no handshake is left open
  assign start_now = pend && ((st == ST_IDLE) || rsp_fire ||
                              ((st == ST_WRITE) && wr_ready));
  assign take      = rsp_fire && !pend && !rd_rsp_timeout;
  assign rec_we    = take && (phase == PH_REC);
  assign last_lane = (idx == IDX_W'(LANES));

  assign core_busy    = (st != ST_IDLE);
  assign rd_req_valid = (st == ST_REQ) && !past_end;
  assign rd_rsp_ready = (st == ST_WAIT);
  assign wr_valid     = (st == ST_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      phase        <= PH_SIG;
      cur_addr     <= '0;
      idx          <= '0;
      stat_loaded  <= 1'b0;
      stat_timeout <= 1'b0;
    end else if (start_now) begin
      st           <= ST_REQ;
      phase        <= PH_SIG;
      cur_addr     <= '0;
      idx          <= '0;
      stat_loaded  <= 1'b0;
      stat_timeout <= 1'b0;
    end else begin
      case (st)
        ST_REQ: begin
          if (past_end) begin
            // device exhausted: a partial record is dropped
            st          <= ST_IDLE;
            stat_loaded <= 1'b1;
          end else if (rd_req_ready) begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_timeout) begin
              st           <= ST_IDLE;
              stat_timeout <= 1'b1;
            end else begin
              cur_addr <= cur_addr + 1'b1;
              if (phase == PH_SIG) begin
                if (rd_rsp_data == SIG_BYTE) begin
                  phase <= PH_REC;
                  st    <= ST_REQ;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (idx == '0 && rd_rsp_data == END_BYTE) begin
                st          <= ST_IDLE;
                stat_loaded <= 1'b1;
              end else if (last_lane) begin
                idx <= '0;
                st  <= ST_WRITE;
              end else begin
                idx <= idx + 1'b1;
                st  <= ST_REQ;
              end
            end
          end
        end
        ST_WRITE: begin
          if (wr_ready) st <= ST_REQ;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
  import cfgld_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         DATA_W    = 32,
  parameter int         MIN_ABITS = 7,
  parameter logic [7:0] SIG_BYTE  = DEF_SIG_BYTE,
  parameter logic [7:0] END_BYTE  = DEF_END_BYTE,
  localparam int ABITS_W = $clog2(ADDR_W + 1),
  localparam int IDX_W   = $clog2(DATA_W / 8 + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_evt,
  input  logic               pin_rst_evt,
  input  logic               dig_rst_evt,
  input  logic               strap_mw,
  input  logic [1:0]         strap_size,
  input  logic               host_reload,
  output logic               cmd_busy,
  output logic               stat_loaded,
  output logic               stat_timeout,
  output logic               eep_mw,
  output logic [ABITS_W-1:0] eep_abits,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_req_addr,
  input  logic               rd_rsp_valid,
  output logic               rd_rsp_ready,
  input  logic [7:0]         rd_rsp_data,
  input  logic               rd_rsp_timeout,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [7:0]         wr_addr,
  output logic [DATA_W-1:0]  wr_data
);
  logic             pend;
  logic             start_now;
  logic             core_busy;
  logic             past_end;
  logic             rec_we;
  logic [ADDR_W:0]  cur_addr;
  logic [IDX_W-1:0] idx;

  cfgld_trig i_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_evt     (por_evt),
    .pin_rst_evt (pin_rst_evt),
    .dig_rst_evt (dig_rst_evt),
    .host_reload (host_reload),
    .core_busy   (core_busy),
    .consume     (start_now),
    .pend        (pend),
    .busy        (cmd_busy)
  );

  cfgld_geom #(.ADDR_W(ADDR_W), .MIN_ABITS(MIN_ABITS)) i_geom (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (start_now),
    .strap_mw   (strap_mw),
    .strap_size (strap_size),
    .cur_addr   (cur_addr),
    .eep_mw     (eep_mw),
    .eep_abits  (eep_abits),
    .past_end   (past_end)
  );

  cfgld_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_BYTE(SIG_BYTE), .END_BYTE(END_BYTE)
  ) i_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .pend           (pend),
    .past_end       (past_end),
    .start_now      (start_now),
    .core_busy      (core_busy),
    .cur_addr       (cur_addr),
    .idx            (idx),
    .rec_we         (rec_we),
    .rd_req_valid   (rd_req_valid),
    .rd_req_ready   (rd_req_ready),
    .rd_rsp_valid   (rd_rsp_valid),
    .rd_rsp_ready   (rd_rsp_ready),
    .rd_rsp_data    (rd_rsp_data),
    .rd_rsp_timeout (rd_rsp_timeout),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .stat_loaded    (stat_loaded),
    .stat_timeout   (stat_timeout)
  );

  cfgld_rec #(.DATA_W(DATA_W)) i_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (rec_we),
    .idx      (idx),
    .din      (rd_rsp_data),
    .rec_addr (wr_addr),
    .rec_data (wr_data)
  );

  assign rd_req_addr = cur_addr[ADDR_W-1:0];
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  localparam int ABITS_W = $clog2(ADDR_W + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               por_evt,
  input logic               pin_rst_evt,
  input logic               dig_rst_evt,
  input logic               cmd_busy,
  input logic               stat_loaded,
  input logic               stat_timeout,
  input logic [ABITS_W-1:0] eep_abits,
  input logic               rd_req_valid,
  input logic               rd_req_ready,
  input logic [ADDR_W-1:0]  rd_req_addr,
  input logic               rd_rsp_ready,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [7:0]         wr_addr,
  input logic [DATA_W-1:0]  wr_data
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_one_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, rd_rsp_ready, wr_valid}));

  assert_cause_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (por_evt || pin_rst_evt || dig_rst_evt) |=> cmd_busy);

  assert_active_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid || wr_valid) |-> cmd_busy);

  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (({1'b0, rd_req_addr} >> eep_abits) == '0));

  assert_status_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_timeout |-> !stat_loaded);
endmodule

bind cfgld_top cfgld_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cfgld_chk (.*);

// File: tb/test_cfgld_top.sv
`timescale 1ns/1ps
module test_cfgld_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_evt = 1'b0, pin_rst_evt = 1'b0, dig_rst_evt = 1'b0;
  logic        strap_mw = 1'b0;
  logic [1:0]  strap_size = 2'd0;
  logic        host_reload = 1'b0;
  logic        cmd_busy, stat_loaded, stat_timeout, eep_mw;
  logic [3:0]  eep_abits;
  logic        rd_req_valid, rd_rsp_ready, wr_valid;
  logic        rd_req_ready = 1'b0;
  logic [9:0]  rd_req_addr;
  logic        rd_rsp_valid = 1'b0, rd_rsp_timeout = 1'b0;
  logic [7:0]  rd_rsp_data = 8'h00;
  logic        wr_ready = 1'b0;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  cfgld_top i_cfgld_top (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [1024];
  int tmo_addr = -1;
  // model state
  logic [39:0] exp_q[$];
  int exp_addr = 0, nreads = 0, e_reads = 0;
  bit e_loaded = 0, e_tmo = 0;
  // stimulus control, written by the main flow just after a rising edge
  int trig_req = 0;
  bit inj_wait = 0;
  int inj_after = 0;
  bit mw_v = 0;
  logic [1:0] size_v = 0;
  // responder state
  bit rsp_pending = 0, rsp_fire = 0, chk_busy_next = 0;
  int rsp_cnt = 0, rsp_addr = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural walk of the image: expected writes, reads and status
  task automatic build_model(input int size);
    int last, a;
    bit done;
    last = (128 << size) - 1;
    exp_q.delete();
    e_loaded = 0; e_tmo = 0; done = 0;
    if (tmo_addr == 0) begin e_tmo = 1; e_reads = 1; done = 1; end
    else if (mem[0] != 8'hA5) begin e_reads = 1; done = 1; end
    a = 1;
    while (!done) begin
      if (a > last) begin e_loaded = 1; e_reads = a; done = 1; end
      else if (a == tmo_addr) begin e_tmo = 1; e_reads = a + 1; done = 1; end
      else if (mem[a] == 8'hFF) begin e_loaded = 1; e_reads = a + 1; done = 1; end
      else begin
        for (int k = 1; k <= 4 && !done; k++) begin
          if (a + k > last) begin e_loaded = 1; e_reads = a + k; done = 1; end
          else if (a + k == tmo_addr) begin e_tmo = 1; e_reads = a + k + 1; done = 1; end
        end
        if (!done) begin
          exp_q.push_back({mem[a], mem[a+4], mem[a+3], mem[a+2], mem[a+1]});
          a += 5;
        end
      end
    end
  endtask

  task automatic fill(input int nrec, input bit with_end);
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 13 + 1);
    mem[0] = 8'hA5;
    for (int k = 0; k < nrec; k++) begin
      mem[1 + 5*k] = 8'(k % 120);
      for (int j = 1; j <= 4; j++) mem[1 + 5*k + j] = 8'(k * 7 + j * 31 + 3);
    end
    if (with_end) mem[1 + 5*nrec] = 8'hFF;
  endtask

  // per-cycle driver, responder, register slave and model comparison
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      por_evt = 0; pin_rst_evt = 0; dig_rst_evt = 0; host_reload = 0;
      strap_mw = mw_v; strap_size = size_v;
      if (chk_busy_next) begin
        chk(cmd_busy == 1'b1, "R10 busy after trigger", cmd_busy, 1);
        chk_busy_next = 0;
      end
      if (rsp_fire) begin rd_rsp_valid = 0; rd_rsp_timeout = 0; rsp_pending = 0; rsp_fire = 0; end
      if (rsp_pending && !rd_rsp_valid) begin
        if (rsp_cnt > 0) rsp_cnt--;
        else begin
          rd_rsp_valid = 1;
          rd_rsp_data = mem[rsp_addr];
          rd_rsp_timeout = (rsp_addr == tmo_addr);
        end
      end
      if (trig_req != 0 && (!inj_wait || (rsp_pending && !rd_rsp_valid && nreads >= inj_after))) begin
        case (trig_req)
          1: por_evt = 1;
          2: pin_rst_evt = 1;
          3: dig_rst_evt = 1;
          default: host_reload = 1;
        endcase
        if (trig_req != 4 || !cmd_busy) begin
          exp_addr = 0; nreads = 0;
          build_model(int'(size_v));
          chk_busy_next = 1;
        end
        trig_req = 0; inj_wait = 0;
      end
      if (rd_rsp_valid && rd_rsp_ready) rsp_fire = 1;
      rd_req_ready = (cyc % 3) != 0;
      if (rd_req_valid && rd_req_ready) begin
        chk(int'(rd_req_addr) == exp_addr, "R5 read address", rd_req_addr, exp_addr);
        exp_addr++; nreads++;
        rsp_pending = 1; rsp_cnt = cyc % 4; rsp_addr = int'(rd_req_addr);
      end
      wr_ready = (cyc % 5) != 1;
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected write", {wr_addr, wr_data}, 0);
        else begin
          chk({wr_addr, wr_data} == exp_q[0], "R5 write record", {wr_addr, wr_data}, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
      if (rd_req_valid || wr_valid)
        chk(cmd_busy == 1'b1, "R10 activity while busy", cmd_busy, 1);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic start(input int kind);
    step();
    trig_req = kind;
    while (trig_req != 0) step();
  endtask

  task automatic finish_load(input string tag);
    int n = 0;
    step();
    while (cmd_busy && n < 20000) begin step(); n++; end
    chk(n < 20000, {tag, " load ends"}, n, 0);
    chk(stat_loaded == e_loaded, {tag, " stat_loaded"}, stat_loaded, e_loaded);
    chk(stat_timeout == e_tmo, {tag, " stat_timeout"}, stat_timeout, e_tmo);
    chk(nreads == e_reads, {tag, " read count"}, nreads, e_reads);
    chk(exp_q.size() == 0, {tag, " writes outstanding"}, exp_q.size(), 0);
    repeat (6) step();
    chk(nreads == e_reads && !cmd_busy, {tag, " no activity after end"}, nreads, e_reads);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    fill(3, 1);
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    step();
    // reset state
    chk(cmd_busy == 0, "R10 idle after reset", cmd_busy, 0);
    chk(stat_loaded == 0 && stat_timeout == 0, "R10 status after reset", {stat_loaded, stat_timeout}, 0);
    chk(!rd_req_valid && !wr_valid, "R9 no valids after reset", {rd_req_valid, wr_valid}, 0);

    // R1: power-on cause, two-wire, smallest size, end marker
    mw_v = 0; size_v = 0; start(1);
    step(); step();
    chk(eep_mw == 0 && eep_abits == 4'd7, "R3 straps two-wire size0", {eep_mw, eep_abits}, 7);
    finish_load("R1 R6 end marker");

    // R6: pin cause, three-wire, size 1, stream fills the whole device
    fill(60, 0); mw_v = 1; size_v = 1; start(2);
    step(); step();
    chk(eep_mw == 1 && eep_abits == 4'd8, "R3 straps three-wire size1", {eep_mw, eep_abits}, 8'h18);
    finish_load("R6 full device");

    // R6: size 0, last record cut off by the limit
    mw_v = 0; size_v = 0; start(2);
    finish_load("R6 partial record dropped");

    // R4: digital cause, bad signature
    mem[0] = 8'h5A; start(3);
    finish_load("R4 bad signature");

    // R7: timeout inside the second record
    fill(4, 1); size_v = 2; tmo_addr = 8; start(1);
    finish_load("R7 timeout");
    tmo_addr = -1;

    // R8: restart with owed response; status from the timeout is cleared
    fill(20, 1); size_v = 3; start(1);
    while (nreads < 2) step();
    chk(stat_timeout == 0, "R8 status cleared at start", stat_timeout, 0);
    while (nreads < 30) step();
    inj_after = 30; inj_wait = 1; trig_req = 3;
    while (trig_req != 0) step();
    while (nreads < 5) step();
    // R3: strap change during the load has no effect
    mw_v = 1; size_v = 0;
    step(); step();
    chk(eep_abits == 4'd10 && eep_mw == 0, "R3 straps held during load", {eep_mw, eep_abits}, 10);
    finish_load("R8 restart");

    // R2: host reload while idle starts; reload while busy is ignored
    fill(6, 1); mw_v = 0; size_v = 0; start(4);
    inj_after = 8; inj_wait = 1; trig_req = 4;
    while (trig_req != 0) step();
    finish_load("R2 reload");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule